// File: doc/BRIEF.md
# Operand Stack with Two-Phase Indexed Exchange

This block is the operand store of a stack-oriented interpreter engine. It holds up to sixteen 16-bit values and takes one command per cycle from the microsequencer: place a value on top, discard the top value, or exchange the top with a deeper entry. The current top value and the current fill level are always visible. The fill level is there so that a trace unit can indent its listing by the nesting depth.

The exchange runs in two microsteps. The first step copies the top entry into one holding register and the entry `k` places below it into a second holding register. The second step writes the two back in crossed positions. The distance `k` comes from the low three bits of the exchange opcode, so the eight opcodes of the exchange family map directly onto distances 0 to 7. Distance 0 changes nothing. Errors on the command path are reported as one-cycle pulses: an overflow flag for a write to a full stack, and an underflow flag for a removal from an empty stack or for an exchange distance that reaches past the bottom.

Top module: `expr_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the stack empties. From the next cycle `depth_o` reads 0, `tos_o` reads 0, and both `ovf_o` and `unf_o` read 0.
- R2: A lone push on a stack holding fewer than 16 entries places `din_i` on top. In the following cycle `tos_o` equals that value and `depth_o` is one higher.
- R3: A lone push on a full stack (16 entries) raises `ovf_o` for exactly the following cycle and leaves the depth and all contents unchanged. `depth_o` never exceeds 16.
- R4: A lone pop on a non-empty stack lowers `depth_o` by one in the following cycle, and `tos_o` then shows the entry that was directly below the old top.
- R5: A lone pop on an empty stack raises `unf_o` for the following cycle and leaves `depth_o` at 0.
- R6: A start-exchange with distance k (1 to 7, k below the depth), followed later by an end-exchange with no push or pop in between, swaps the top entry and the entry k places below it. `depth_o` does not change.
- R7: A start-exchange with distance 0 changes neither depth nor contents and raises no flag.
- R8: A start-exchange with a nonzero distance at or above the current depth raises `unf_o` for the following cycle, leaves the stack unmodified, and cancels any pending exchange.
- R9: An end-exchange with no pending exchange has no effect. A successful push or pop cancels a pending exchange, so a later end-exchange then does nothing.
- R10: When more than one of the four command inputs is high in the same cycle, no command executes and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Place `din_i` on top |
| pop_i | input | 1 | Discard the top entry |
| xstart_i | input | 1 | Exchange phase one: latch top and the entry at distance `idx_i` |
| xend_i | input | 1 | Exchange phase two: write the latched pair back crossed |
| idx_i | input | 3 | Exchange distance from the top (opcode low bits) |
| din_i | input | 16 | Value to push |
| tos_o | output | 16 | Current top entry, 0 when empty |
| depth_o | output | 5 | Number of entries held (0 to 16) |
| ovf_o | output | 1 | One-cycle pulse: push on a full stack was dropped |
| unf_o | output | 1 | One-cycle pulse: pop on empty or exchange distance too deep |

## Verification
The bound checker watches every cycle for depth movement on single push and pop commands, the overflow and underflow pulses with depth held, the depth ceiling, depth stability across both exchange phases and distance 0, and full inertness under conflicting commands. Whether an exchange actually moved the right two values, whether an interrupted exchange is really abandoned, and whether a rejected command left the deeper contents intact can only be shown by the bench scenarios. These scenarios drain the stack with pops and compare every value that appears on top against a reference model.

// File: rtl/exs_pkg.sv
package exs_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_XSTART,
    OP_XEND,
    OP_CLASH
  } exs_op_e;
endpackage

// File: rtl/exs_regfile.sv
module exs_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_a,
  input  logic [AW-1:0]     waddr_a,
  input  logic [DATA_W-1:0] wdata_a,
  input  logic              we_b,
  input  logic [AW-1:0]     waddr_b,
  input  logic [DATA_W-1:0] wdata_b,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] cells [DEPTH];

  // Two write ports are needed only for the crossed write-back of an exchange;
  // the addresses never collide because the distance is at least one.
  always_ff @(posedge clk) begin
    if (we_a) cells[waddr_a] <= wdata_a;
    if (we_b) cells[waddr_b] <= wdata_b;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/exs_depth_ctr.sv
module exs_depth_ctr #(
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grow,
  input  logic             shrink,
  input  logic             err_over,
  input  logic             err_under,
  output logic [PTR_W-1:0] level_q,
  output logic             ovf_q,
  output logic             unf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      if (grow)        level_q <= level_q + PTR_W'(1);
      else if (shrink) level_q <= level_q - PTR_W'(1);
      ovf_q <= err_over;
      unf_q <= err_under;
    end
  end
endmodule

// File: rtl/exs_swap_unit.sv
module exs_swap_unit #(
  parameter int DATA_W = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              cancel,
  input  logic              fire_req,
  input  logic [DATA_W-1:0] top_val,
  input  logic [DATA_W-1:0] deep_val,
  input  logic [AW-1:0]     deep_addr,
  output logic              commit,
  output logic [DATA_W-1:0] hold_r,
  output logic [DATA_W-1:0] hold_s,
  output logic [AW-1:0]     hold_pos
);
  logic armed_q;

  assign commit = fire_req & armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (arm) begin
      armed_q <= 1'b1;
    end else if (cancel || commit) begin
      armed_q <= 1'b0;
    end
  end

  // Holding registers carry data only; no reset so they map to plain flops.
  always_ff @(posedge clk) begin
    if (arm) begin
      hold_r   <= top_val;
      hold_s   <= deep_val;
      hold_pos <= deep_addr;
    end
  end
endmodule

// File: rtl/expr_stack.sv
module expr_stack #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              xstart_i,
  input  logic              xend_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] tos_o,
  output logic [PTR_W-1:0]  depth_o,
  output logic              ovf_o,
  output logic              unf_o
);
  import exs_pkg::*;

  exs_op_e           op;
  logic [PTR_W-1:0]  level;
  logic              full, empty;
  logic [AW-1:0]     top_addr, deep_addr;
  logic [DATA_W-1:0] top_val, deep_val;
  logic              push_ok, push_bad, pop_ok, pop_bad;
  logic              xs_ok, xs_bad, commit;
  logic [DATA_W-1:0] hold_r, hold_s;
  logic [AW-1:0]     hold_pos;
  logic              we_a;
  logic [AW-1:0]     waddr_a;
  logic [DATA_W-1:0] wdata_a;

  // One command per cycle; a clash of commands is dropped entirely.
  always_comb begin
    unique case ({push_i, pop_i, xstart_i, xend_i})
      4'b0000: op = OP_IDLE;
      4'b1000: op = OP_PUSH;
      4'b0100: op = OP_POP;
      4'b0010: op = OP_XSTART;
      4'b0001: op = OP_XEND;
      default: op = OP_CLASH;
    endcase
  end

  assign full  = (level == PTR_W'(DEPTH));
  assign empty = (level == '0);

  assign top_addr  = AW'(level - PTR_W'(1));
  assign deep_addr = AW'(level - PTR_W'(1) - PTR_W'(idx_i));

  assign push_ok  = (op == OP_PUSH) && !full;
  assign push_bad = (op == OP_PUSH) && full;
  assign pop_ok   = (op == OP_POP) && !empty;
  assign pop_bad  = (op == OP_POP) && empty;
  // Distance 0 is a pure no-op: it neither arms nor flags.
  assign xs_ok    = (op == OP_XSTART) && (idx_i != '0) && (PTR_W'(idx_i) < level);
  assign xs_bad   = (op == OP_XSTART) && (idx_i != '0) && (PTR_W'(idx_i) >= level);

  exs_depth_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .grow      (push_ok),
    .shrink    (pop_ok),
    .err_over  (push_bad),
    .err_under (pop_bad | xs_bad),
    .level_q   (level),
    .ovf_q     (ovf_o),
    .unf_q     (unf_o)
  );

  exs_swap_unit #(.DATA_W(DATA_W), .AW(AW)) u_swap (
    .clk       (clk),
    .rst       (rst),
    .arm       (xs_ok),
    .cancel    (push_ok | pop_ok | xs_bad),
    .fire_req  (op == OP_XEND),
    .top_val   (top_val),
    .deep_val  (deep_val),
    .deep_addr (deep_addr),
    .commit    (commit),
    .hold_r    (hold_r),
    .hold_s    (hold_s),
    .hold_pos  (hold_pos)
  );

  // Port A: push writes the slot above the top; exchange end writes S into the top.
  assign we_a    = push_ok | commit;
  assign waddr_a = push_ok ? AW'(level) : top_addr;
  assign wdata_a = push_ok ? din_i : hold_s;

  exs_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
    .clk     (clk),
    .we_a    (we_a),
    .waddr_a (waddr_a),
    .wdata_a (wdata_a),
    .we_b    (commit),
    .waddr_b (hold_pos),
    .wdata_b (hold_r),
    .raddr_a (top_addr),
    .rdata_a (top_val),
    .raddr_b (deep_addr),
    .rdata_b (deep_val)
  );

  assign tos_o   = empty ? '0 : top_val;
  assign depth_o = level;
endmodule

// File: rtl/expr_stack_chk.sv
module expr_stack_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 3,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              push_i,
  input logic              pop_i,
  input logic              xstart_i,
  input logic              xend_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic [DATA_W-1:0] din_i,
  input logic [DATA_W-1:0] tos_o,
  input logic [PTR_W-1:0]  depth_o,
  input logic              ovf_o,
  input logic              unf_o
);
  logic [3:0] cmds;
  logic       single;
  assign cmds   = {push_i, pop_i, xstart_i, xend_i};
  assign single = ($countones(cmds) == 1);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (depth_o == '0 && !ovf_o && !unf_o));

  assert_push_R2: assert property (@(posedge clk) disable iff (rst)
    (single && push_i && depth_o < PTR_W'(DEPTH)) |=>
      (depth_o == $past(depth_o) + PTR_W'(1) && tos_o == $past(din_i)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    depth_o <= PTR_W'(DEPTH));

  assert_full_push_R3: assert property (@(posedge clk) disable iff (rst)
    (single && push_i && depth_o == PTR_W'(DEPTH)) |=>
      (ovf_o && depth_o == PTR_W'(DEPTH)));

  assert_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (single && pop_i && depth_o != '0) |=> (depth_o == $past(depth_o) - PTR_W'(1)));

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (single && pop_i && depth_o == '0) |=> (unf_o && depth_o == '0));

  assert_xend_depth_R6: assert property (@(posedge clk) disable iff (rst)
    (single && (xend_i || xstart_i)) |=> (depth_o == $past(depth_o)));

  assert_zero_dist_R7: assert property (@(posedge clk) disable iff (rst)
    (single && xstart_i && idx_i == '0) |=> (!unf_o && tos_o == $past(tos_o)));

  assert_deep_dist_R8: assert property (@(posedge clk) disable iff (rst)
    (single && xstart_i && idx_i != '0 && PTR_W'(idx_i) >= depth_o) |=> unf_o);

  assert_clash_R10: assert property (@(posedge clk) disable iff (rst)
    ($countones(cmds) > 1) |=>
      (depth_o == $past(depth_o) && tos_o == $past(tos_o) && !ovf_o && !unf_o));
endmodule

bind expr_stack expr_stack_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .push_i   (push_i),
  .pop_i    (pop_i),
  .xstart_i (xstart_i),
  .xend_i   (xend_i),
  .idx_i    (idx_i),
  .din_i    (din_i),
  .tos_o    (tos_o),
  .depth_o  (depth_o),
  .ovf_o    (ovf_o),
  .unf_o    (unf_o)
);

// File: tb/expr_stack_test.sv
module expr_stack_test;
  localparam int PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 0, pop_i = 0, xstart_i = 0, xend_i = 0;
  logic [2:0]  idx_i = '0;
  logic [15:0] din_i = '0;
  logic [15:0] tos_o;
  logic [4:0]  depth_o;
  logic        ovf_o, unf_o;

  always #(PERIOD/2) clk = ~clk;

  expr_stack uut (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .xstart_i(xstart_i),
    .xend_i(xend_i), .idx_i(idx_i), .din_i(din_i), .tos_o(tos_o),
    .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  typedef struct {
    logic [15:0] tos;
    logic [4:0]  depth;
    logic        ovf;
    logic        unf;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] mdl[$];
  bit          armed = 0;
  int          apos = 0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  function automatic exp_t snap(string tag);
    exp_t e;
    e.tos   = (mdl.size() == 0) ? 16'h0 : mdl[mdl.size()-1];
    e.depth = 5'(mdl.size());
    e.ovf   = 0;
    e.unf   = 0;
    e.tag   = tag;
    return e;
  endfunction

  // Driver: applies one cycle of command, updates the model, queues the expectation.
  task automatic cmd(bit p, bit q, bit xs, bit xe, logic [2:0] ix, logic [15:0] d, string tag);
    exp_t e;
    int   n = int'(p) + int'(q) + int'(xs) + int'(xe);
    bit   eo = 0, eu = 0;
    @(negedge clk);
    push_i = p; pop_i = q; xstart_i = xs; xend_i = xe; idx_i = ix; din_i = d;
    if (n == 1) begin
      if (p) begin
        if (mdl.size() == 16) eo = 1;
        else begin mdl.push_back(d); armed = 0; end
      end
      if (q) begin
        if (mdl.size() == 0) eu = 1;
        else begin void'(mdl.pop_back()); armed = 0; end
      end
      if (xs && ix != 0) begin
        if (int'(ix) >= mdl.size()) begin eu = 1; armed = 0; end
        else begin armed = 1; apos = mdl.size() - 1 - int'(ix); end
      end
      if (xe && armed) begin
        logic [15:0] t;
        t = mdl[mdl.size()-1];
        mdl[mdl.size()-1] = mdl[apos];
        mdl[apos] = t;
        armed = 0;
      end
    end
    @(posedge clk); #1;
    push_i = 0; pop_i = 0; xstart_i = 0; xend_i = 0;
    e = snap(tag);
    e.ovf = eo;
    e.unf = eu;
    sb.push_back(e);
  endtask

  // Monitor: compares outputs one half-period after the edge that produced them.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (tos_o !== e.tos || depth_o !== e.depth || ovf_o !== e.ovf || unf_o !== e.unf) begin
        n_bad++;
        $display("FAIL %s: tos=%h depth=%0d ovf=%b unf=%b expected tos=%h depth=%0d ovf=%b unf=%b",
                 e.tag, tos_o, depth_o, ovf_o, unf_o, e.tos, e.depth, e.ovf, e.unf);
      end
    end
  end

  task automatic drain_check(string tag);
    int k = mdl.size();
    for (int i = 0; i < k; i++) cmd(0, 1, 0, 0, 3'd0, 16'h0, tag);
  endtask

  initial begin
    exp_t e;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    e = snap("R1 reset state");
    sb.push_back(e);

    cmd(0, 1, 0, 0, 3'd0, 16'h0, "R5 pop on empty");
    cmd(0, 0, 0, 0, 3'd0, 16'h0, "R5 flag clears");
    for (int i = 0; i < 16; i++) cmd(1, 0, 0, 0, 3'd0, 16'hA000 + 16'(i * 17), "R2 push");
    cmd(1, 0, 0, 0, 3'd0, 16'hDEAD, "R3 push on full");
    cmd(0, 0, 0, 0, 3'd0, 16'h0, "R3 flag one cycle");
    cmd(0, 0, 1, 0, 3'd0, 16'h0, "R7 distance zero start");
    cmd(0, 0, 0, 1, 3'd0, 16'h0, "R9 end with nothing pending");
    cmd(0, 0, 1, 0, 3'd3, 16'h0, "R6 start k=3");
    cmd(0, 0, 0, 1, 3'd0, 16'h0, "R6 end k=3");
    cmd(0, 0, 1, 0, 3'd7, 16'h0, "R6 start k=7");
    cmd(0, 0, 0, 0, 3'd0, 16'h0, "R6 idle between phases");
    cmd(0, 0, 0, 1, 3'd0, 16'h0, "R6 end k=7");
    cmd(0, 1, 0, 0, 3'd0, 16'h0, "R4 pop");
    cmd(0, 0, 1, 0, 3'd2, 16'h0, "R9 start before cancel");
    cmd(1, 0, 0, 0, 3'd0, 16'h5A5A, "R9 push cancels");
    cmd(0, 0, 0, 1, 3'd0, 16'h0, "R9 end after cancel");
    cmd(1, 1, 0, 0, 3'd0, 16'h1234, "R10 push and pop together");
    cmd(0, 0, 1, 1, 3'd1, 16'h0, "R10 start and end together");
    cmd(1, 0, 0, 0, 3'd0, 16'h7777, "R3 push on full again");
    for (int i = 0; i < 13; i++) cmd(0, 1, 0, 0, 3'd0, 16'h0, "R4 pop down");
    cmd(0, 0, 1, 0, 3'd1, 16'h0, "R6 start k=1 shallow");
    cmd(0, 0, 0, 1, 3'd0, 16'h0, "R6 end k=1 shallow");
    cmd(0, 0, 1, 0, 3'd1, 16'h0, "R8 start k=1 to arm");
    cmd(0, 0, 1, 0, 3'd5, 16'h0, "R8 distance too deep");
    cmd(0, 0, 0, 1, 3'd0, 16'h0, "R8 end after rejected start");
    cmd(0, 0, 1, 0, 3'd3, 16'h0, "R8 distance equals depth");
    drain_check("R4 drain contents");
    cmd(0, 1, 0, 0, 3'd0, 16'h0, "R5 pop on empty again");
    cmd(0, 0, 1, 0, 3'd0, 16'h0, "R7 distance zero on empty");
    cmd(0, 0, 0, 0, 3'd0, 16'h0, "R1 idle final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule